// File: doc/BRIEF.md
# Speculative Broadcast Fanout Node

This block is a one-input, multi-output routing node for a tree-shaped on-chip network. Its input channel and each output channel use a transition-signalled request/acknowledge pair. A bundled data word travels with each request and carries a 2-bit flit kind and a payload. The node does no route computation. Every packet head is copied to all output branches. Each branch then reports on a `kept` line whether the node downstream accepted the head or dropped it as misrouted. Body and tail flits of that packet go only to one branch that kept the head. When the tail has passed, the node goes back to broadcasting.

The payload is never decoded or trimmed, so packets need no routing field for this node. The node holds exactly one flit. It accepts a new flit only when every copy of the previous flit has been acknowledged. If no branch kept the head, the node swallows the body and tail flits of that packet and acknowledges them itself.

Top module: `spec_fanout_node`

## Requirements
- R1: After a synchronous reset, `in_ack` and every `out_req` bit are 0, and the node is in broadcast mode. A body flit (kind 01) sent first is therefore copied to all branches.
- R2: A head flit (kind 00) is always copied to every branch. Every `out_req` bit toggles on the clock edge that accepts the flit.
- R3: `in_ack` toggles only on the edge after the last of the targeted branches has toggled its `out_ack`. While any targeted branch is still pending, `in_ack` holds.
- R4: After a head, body flits (kind 01) toggle the `out_req` of exactly one branch. That branch is the lowest-index branch that drove `kept`=1 when it acknowledged the head (the highest-index branch when `PICK_HIGH`=1).
- R5: A tail flit (kind 10) in narrowed mode goes to the selected branch only, and then restores broadcast mode, so the next head reaches every branch.
- R6: A single-flit packet (kind 11) is copied to every branch and leaves the node in broadcast mode.
- R7: If no branch kept the head, body and tail flits toggle no `out_req`, and `in_ack` toggles on the edge that accepts them.
- R8: `out_kind` and `out_payload` equal the accepted flit, with the payload unaltered in every bit. They stay stable while any branch is pending.
- R9: A body or tail flit that arrives while the node is in broadcast mode is copied to every branch.
- R10: `in_ack` never toggles unless a request is outstanding, meaning `in_req` differs from `in_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_req | input | 1 | Input request phase; a toggle offers a flit |
| in_ack | output | 1 | Input acknowledge phase; a toggle consumes the flit |
| in_kind | input | 2 | Flit kind: 00 head, 01 body, 10 tail, 11 single |
| in_payload | input | PAYLOAD_W | Flit payload |
| out_req | output | NUM_OUT | Per-branch request phase |
| out_ack | input | NUM_OUT | Per-branch acknowledge phase |
| out_kept | input | NUM_OUT | Per-branch report, valid with the head acknowledge: 1 means the head was kept |
| out_kind | output | 2 | Kind of the held flit, shared by all branches |
| out_payload | output | PAYLOAD_W | Payload of the held flit, shared by all branches |

## Verification
The assertions assume well-behaved neighbours. The input side toggles `in_req` only when `in_ack` equals it, and holds the data while the request is outstanding. A branch toggles `out_ack` only while its request is pending, and holds `kept` steady across the edge that sees the acknowledge. The bench meets these by driving every input at the falling edge. It waits for `in_ack` before it offers the next flit, and it acknowledges only the branches it expects to be targeted, one per cycle and in random order. The random packets are mostly well formed, with random `kept` patterns that include all branches dropping the head. Directed cases add an out-of-order body flit to cover broadcast mode.

// File: rtl/sfn_pkg.sv
package sfn_pkg;

   typedef enum logic [1:0] {
      FK_HEAD = 2'b00,
      FK_BODY = 2'b01,
      FK_TAIL = 2'b10,
      FK_SOLO = 2'b11
   } flit_kind_e;

   typedef enum logic {
      MODE_SPREAD = 1'b0,
      MODE_NARROW = 1'b1
   } fan_mode_e;

   function automatic logic kind_forces_spread(flit_kind_e k);
      return (k == FK_HEAD) || (k == FK_SOLO);
   endfunction

endpackage

// File: rtl/sfn_flit_reg.sv
module sfn_flit_reg
   import sfn_pkg::*;
#(
   parameter int PAYLOAD_W = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 load,
   input  flit_kind_e           kind_in,
   input  logic [PAYLOAD_W-1:0] payload_in,
   output flit_kind_e           kind_q,
   output logic [PAYLOAD_W-1:0] payload_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         kind_q    <= FK_HEAD;
         payload_q <= '0;
      end else if (load) begin
         kind_q    <= kind_in;
         payload_q <= payload_in;
      end
   end

endmodule

// File: rtl/sfn_branch_join.sv
module sfn_branch_join #(
   parameter int NUM_OUT = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               launch,
   input  logic [NUM_OUT-1:0] launch_mask,
   input  logic               sample_kept,
   input  logic [NUM_OUT-1:0] out_ack,
   input  logic [NUM_OUT-1:0] out_kept,
   output logic [NUM_OUT-1:0] out_req,
   output logic               all_done,
   output logic [NUM_OUT-1:0] kept_nx
);

   logic [NUM_OUT-1:0] req_q;
   logic [NUM_OUT-1:0] pend;

   for (genvar b = 0; b < NUM_OUT; b++) begin : g_branch
      logic mask_q;
      logic seen_q;
      logic kept_q;
      logic cap;

      assign pend[b]    = req_q[b] ^ out_ack[b];
      assign cap        = sample_kept && mask_q && !pend[b] && !seen_q;
      assign kept_nx[b] = cap ? out_kept[b] : kept_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            req_q[b] <= 1'b0;
            mask_q   <= 1'b0;
            seen_q   <= 1'b0;
            kept_q   <= 1'b0;
         end else if (launch) begin
            req_q[b] <= req_q[b] ^ launch_mask[b];
            mask_q   <= launch_mask[b];
            seen_q   <= 1'b0;
            kept_q   <= 1'b0;
         end else if (cap) begin
            seen_q   <= 1'b1;
            kept_q   <= out_kept[b];
         end
      end
   end

   assign all_done = (pend == '0);
   assign out_req  = req_q;

endmodule

// File: rtl/sfn_mode_ctrl.sv
module sfn_mode_ctrl
   import sfn_pkg::*;
#(
   parameter int NUM_OUT   = 2,
   parameter bit PICK_HIGH = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               finish,
   input  flit_kind_e         finish_kind,
   input  logic [NUM_OUT-1:0] kept_vec,
   output fan_mode_e          mode,
   output logic [NUM_OUT-1:0] sel_mask
);

   logic [NUM_OUT-1:0] pick;

   if (PICK_HIGH) begin : g_pick_high
      always_comb begin
         pick = '0;
         for (int i = 0; i < NUM_OUT; i++) begin
            if (kept_vec[i]) begin
               pick    = '0;
               pick[i] = 1'b1;
            end
         end
      end
   end else begin : g_pick_low
      always_comb begin
         pick = '0;
         for (int i = NUM_OUT - 1; i >= 0; i--) begin
            if (kept_vec[i]) begin
               pick    = '0;
               pick[i] = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mode     <= MODE_SPREAD;
         sel_mask <= '0;
      end else if (finish) begin
         case (finish_kind)
            FK_HEAD: begin
               mode     <= MODE_NARROW;
               sel_mask <= pick;
            end
            FK_TAIL, FK_SOLO: begin
               mode     <= MODE_SPREAD;
               sel_mask <= '0;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/spec_fanout_node.sv
module spec_fanout_node
   import sfn_pkg::*;
#(
   parameter int NUM_OUT   = 2,
   parameter int PAYLOAD_W = 16,
   parameter bit PICK_HIGH = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_req,
   output logic                 in_ack,
   input  logic [1:0]           in_kind,
   input  logic [PAYLOAD_W-1:0] in_payload,
   output logic [NUM_OUT-1:0]   out_req,
   input  logic [NUM_OUT-1:0]   out_ack,
   input  logic [NUM_OUT-1:0]   out_kept,
   output logic [1:0]           out_kind,
   output logic [PAYLOAD_W-1:0] out_payload
);

   localparam logic [NUM_OUT-1:0] ALL_BRANCHES = {NUM_OUT{1'b1}};

   if (NUM_OUT < 2) begin : g_bad_fanout
      $error("spec_fanout_node: NUM_OUT must be at least 2");
   end
   if (PAYLOAD_W < 1) begin : g_bad_payload
      $error("spec_fanout_node: PAYLOAD_W must be at least 1");
   end

   flit_kind_e         kind_in;
   flit_kind_e         kind_q;
   fan_mode_e          mode;
   logic [NUM_OUT-1:0] sel_mask;
   logic [NUM_OUT-1:0] target;
   logic [NUM_OUT-1:0] kept_nx;
   logic               ack_q;
   logic               busy_q;
   logic               new_req;
   logic               launch;
   logic               discard;
   logic               all_done;
   logic               finish;
   flit_kind_e         finish_kind;

   assign kind_in = flit_kind_e'(in_kind);
   assign new_req = (in_req != ack_q) && !busy_q;
   assign target  = (kind_forces_spread(kind_in) || mode == MODE_SPREAD)
                    ? ALL_BRANCHES : sel_mask;
   assign launch  = new_req && (target != '0);
   assign discard = new_req && (target == '0);
   assign finish  = discard || (busy_q && all_done);
   assign finish_kind = discard ? kind_in : kind_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ack_q  <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         if (finish) ack_q <= ~ack_q;
         if (launch) busy_q <= 1'b1;
         else if (busy_q && all_done) busy_q <= 1'b0;
      end
   end

   sfn_flit_reg #(.PAYLOAD_W(PAYLOAD_W)) flit_i (
      .clk        (clk),
      .rst        (rst),
      .load       (launch),
      .kind_in    (kind_in),
      .payload_in (in_payload),
      .kind_q     (kind_q),
      .payload_q  (out_payload)
   );

   sfn_branch_join #(.NUM_OUT(NUM_OUT)) join_i (
      .clk         (clk),
      .rst         (rst),
      .launch      (launch),
      .launch_mask (target),
      .sample_kept (busy_q && kind_q == FK_HEAD),
      .out_ack     (out_ack),
      .out_kept    (out_kept),
      .out_req     (out_req),
      .all_done    (all_done),
      .kept_nx     (kept_nx)
   );

   sfn_mode_ctrl #(.NUM_OUT(NUM_OUT), .PICK_HIGH(PICK_HIGH)) mode_i (
      .clk         (clk),
      .rst         (rst),
      .finish      (finish),
      .finish_kind (finish_kind),
      .kept_vec    (kept_nx),
      .mode        (mode),
      .sel_mask    (sel_mask)
   );

   assign in_ack   = ack_q;
   assign out_kind = kind_q;

endmodule

// File: rtl/spec_fanout_node_chk.sv
module spec_fanout_node_chk #(
   parameter int NUM_OUT   = 2,
   parameter int PAYLOAD_W = 16
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 in_req,
   input logic                 in_ack,
   input logic [NUM_OUT-1:0]   out_req,
   input logic [NUM_OUT-1:0]   out_ack,
   input logic [1:0]           out_kind,
   input logic [PAYLOAD_W-1:0] out_payload
);

   assert_reset_idle_R1: assert property (@(posedge clk)
      $past(rst) |-> (in_ack == 1'b0 && out_req == '0));

   assert_head_to_all_R2: assert property (@(posedge clk) disable iff (rst)
      (!$stable(out_req) && out_kind == 2'b00) |-> ((out_req ^ $past(out_req)) == {NUM_OUT{1'b1}}));

   assert_solo_to_all_R6: assert property (@(posedge clk) disable iff (rst)
      (!$stable(out_req) && out_kind == 2'b11) |-> ((out_req ^ $past(out_req)) == {NUM_OUT{1'b1}}));

   assert_join_complete_R3: assert property (@(posedge clk) disable iff (rst)
      !$stable(in_ack) |-> ($past(out_req ^ out_ack) == '0));

   assert_body_one_or_all_R4: assert property (@(posedge clk) disable iff (rst)
      (!$stable(out_req) && out_kind[1] != out_kind[0])
      |-> ($countones(out_req ^ $past(out_req)) == 1
           || $countones(out_req ^ $past(out_req)) == NUM_OUT));

   assert_data_held_R8: assert property (@(posedge clk) disable iff (rst)
      (|(out_req ^ out_ack)) |=> ($stable(out_payload) && $stable(out_kind)));

   assert_ack_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
      !$stable(in_ack) |-> ($past(in_req) != $past(in_ack)));

endmodule

bind spec_fanout_node spec_fanout_node_chk #(
   .NUM_OUT   (NUM_OUT),
   .PAYLOAD_W (PAYLOAD_W)
) chk_i (
   .clk         (clk),
   .rst         (rst),
   .in_req      (in_req),
   .in_ack      (in_ack),
   .out_req     (out_req),
   .out_ack     (out_ack),
   .out_kind    (out_kind),
   .out_payload (out_payload)
);

// File: tb/spec_fanout_node_tb_top.sv
module spec_fanout_node_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NO = 2;
   localparam int PW = 16;
   localparam int WATCHDOG = 150000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_req = 1'b0;
   logic          in_ack;
   logic [1:0]    in_kind = 2'b00;
   logic [PW-1:0] in_payload = '0;
   logic [NO-1:0] out_req;
   logic [NO-1:0] out_ack = '0;
   logic [NO-1:0] out_kept = '0;
   logic [1:0]    out_kind;
   logic [PW-1:0] out_payload;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   // reference state of the bench
   bit            ref_narrow = 1'b0;
   logic [NO-1:0] ref_sel = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spec_fanout_node #(.NUM_OUT(NO), .PAYLOAD_W(PW), .PICK_HIGH(1'b0)) dut_i (
      .clk         (clk),
      .rst         (rst),
      .in_req      (in_req),
      .in_ack      (in_ack),
      .in_kind     (in_kind),
      .in_payload  (in_payload),
      .out_req     (out_req),
      .out_ack     (out_ack),
      .out_kept    (out_kept),
      .out_kind    (out_kind),
      .out_payload (out_payload)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [NO-1:0] pick_low(logic [NO-1:0] k);
      for (int i = 0; i < NO; i++) if (k[i]) return NO'(1) << i;
      return '0;
   endfunction

   function automatic logic [NO-1:0] exp_target(logic [1:0] k);
      if (k == 2'b00 || k == 2'b11 || !ref_narrow) return '1;
      return ref_sel;
   endfunction

   // kinds: 00 head, 01 body, 10 tail, 11 single
   task automatic send(input logic [1:0] kind, input logic [PW-1:0] pay,
                       input logic [NO-1:0] kept, input bit hi_first, input string tag);
      logic [NO-1:0] tgt;
      logic [NO-1:0] req0;
      logic          ack0;
      tgt  = exp_target(kind);
      req0 = out_req;
      ack0 = in_ack;
      @(negedge clk);
      in_kind    = kind;
      in_payload = pay;
      in_req     = ~in_req;
      @(negedge clk);
      if (tgt == '0) begin
         check(in_ack == ~ack0, "R7 self-ack", 32'(in_ack), 32'(~ack0));
         check(out_req == req0, "R7 no forward", 32'(out_req), 32'(req0));
      end else begin
         check(out_req == (req0 ^ tgt), tag, 32'(out_req), 32'(req0 ^ tgt));
         check(in_ack == ack0, "R3 early ack", 32'(in_ack), 32'(ack0));
         check(out_kind == kind && out_payload == pay, "R8 data",
               {14'd0, out_kind, out_payload}, {14'd0, kind, pay});
         for (int s = 0; s < NO; s++) begin
            int p;
            p = hi_first ? NO - 1 - s : s;
            if (tgt[p]) begin
               out_kept[p] = kept[p];
               out_ack[p]  = ~out_ack[p];
               @(negedge clk);
               if ((out_req ^ out_ack) == '0)
                  check(in_ack == ~ack0, "R3 join ack", 32'(in_ack), 32'(~ack0));
               else begin
                  check(in_ack == ack0, "R3 partial", 32'(in_ack), 32'(ack0));
                  check(out_payload == pay, "R8 held", 32'(out_payload), 32'(pay));
               end
            end
         end
      end
      if (kind == 2'b00) begin
         ref_narrow = 1'b1;
         ref_sel    = pick_low(kept);
      end else if (kind == 2'b10 || kind == 2'b11) begin
         ref_narrow = 1'b0;
         ref_sel    = '0;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(in_ack == 1'b0 && out_req == '0, "R1 reset", {out_req, in_ack}, 0);
      // R1 / R9: first body in broadcast mode reaches all
      send(2'b01, 16'hA5A5, 2'b00, 1'b0, "R1 broadcast after reset");
      send(2'b10, 16'h0F0F, 2'b00, 1'b1, "R9 tail in broadcast");
      // R2/R4: head kept by branch 1 only
      send(2'b00, 16'h1234, 2'b10, 1'b0, "R2 head");
      send(2'b01, 16'hFFFF, 2'b00, 1'b0, "R4 body to branch 1");
      send(2'b10, 16'h8001, 2'b00, 1'b0, "R5 tail narrowed");
      send(2'b00, 16'h2222, 2'b11, 1'b1, "R5 head after tail");
      send(2'b01, 16'h3333, 2'b00, 1'b0, "R4 lowest kept");
      send(2'b10, 16'h4444, 2'b00, 1'b0, "R5 tail");
      // R7: all dropped
      send(2'b00, 16'h5555, 2'b00, 1'b0, "R2 head dropped");
      send(2'b01, 16'h6666, 2'b00, 1'b0, "R7");
      send(2'b10, 16'h7777, 2'b00, 1'b0, "R7");
      send(2'b11, 16'h9999, 2'b01, 1'b1, "R6 single");
      send(2'b01, 16'hAAAA, 2'b00, 1'b0, "R6 stays broadcast");
      // random packets
      for (int pk = 0; pk < 200; pk++) begin
         int r;
         r = $urandom % 5;
         if (r == 0)
            send(2'b11, 16'($urandom), 2'($urandom), 1'($urandom), "R6 single");
         else begin
            send(2'b00, 16'($urandom), 2'($urandom), 1'($urandom), "R2 head");
            for (int b = 0; b < r - 1; b++)
               send(2'b01, 16'($urandom), 2'($urandom), 1'($urandom), "R4 body");
            send(2'b10, 16'($urandom), 2'($urandom), 1'($urandom), "R5 tail");
         end
      end
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule